// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block holds three alarm registers (alarm minutes, alarm hours, alarm day-of-week) and compares them with the running time that a separate clock block supplies. The alarm registers use the same BCD layout as the time registers. Bit 7 of each alarm register is a "don't care" mask. The three masks nest, so that together they select one of four alarm rates: an exact day/hour/minute match, a daily alarm, an hourly alarm, or an alarm once every minute.

The clock block pulses `eval_stb_i` once in each evaluation window, which is the period in which hundredths of a second read 99. It also pulses `sec_roll_i` when seconds wrap from 59 to 00. When an alarm fires, the block sets a sticky flag and pulls an active-low interrupt. Software acknowledges the alarm by reading or writing any alarm register. In a match-based rate, a match fires only on the first evaluation of a run of matching evaluations. Writing an alarm register re-arms this detection.

Top module: `tod_alarm_matcher`

## Requirements
- R1: The alarm minutes, hours and day registers sit at bus addresses 3, 5 and 7. Addresses 3 and 5 read back all 8 written bits. Address 7 reads back bit 7 and bits 2:0, and bits 6:3 always read 0. Any other address reads 0.
- R2: With all three masks clear (bit 7 = 0 in all alarm registers), an evaluation strobe fires the alarm only when the current minutes equal alarm bits 6:0, the current hours equal alarm bits 6:0 (12/24-hour and AM/PM bits included), and the current day equals alarm bits 2:0.
- R3: With only the day mask set (address 7 bit 7), an evaluation strobe fires on a match of minutes and hours, whatever the day.
- R4: With the day and hour masks set (bit 7 of addresses 7 and 5), an evaluation strobe fires on a minutes match alone.
- R5: With the minute mask set (address 3 bit 7), the alarm fires on each seconds-rollover strobe and ignores evaluation strobes. Without it, seconds-rollover strobes have no effect.
- R6: The masks nest. A set hour mask implies the day mask, and a set minute mask implies both other masks. For example, the hour mask alone gives the hourly rate.
- R7: In a match-based rate, an evaluation fires only if the previous evaluation did not match. A write to any alarm register re-arms this, so the next matching evaluation fires.
- R8: The flag rises in the clock edge that samples the firing strobe. It then holds until it is acknowledged or reset. `alarm_irq_no` is low exactly while the flag is set.
- R9: A read or write strobe at address 3, 5 or 7 clears the flag at that clock edge. Accesses to other addresses leave the flag unchanged.
- R10: When an alarm fires in the same cycle as an acknowledging access, the flag ends up set.
- R11: After reset the flag is clear, `alarm_irq_no` is high, and all alarm registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 7 | Current hours, BCD with 12/24 and AM/PM bits |
| cur_day_i | input | 3 | Current day of week |
| eval_stb_i | input | 1 | One-cycle strobe in the evaluation window |
| sec_roll_i | input | 1 | One-cycle strobe on seconds 59 to 00 |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe |
| bus_addr_i | input | 4 | Bus register address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data for the addressed alarm register |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| alarm_irq_no | output | 1 | Alarm interrupt, active low |

## Verification
The bench builds the block with its default parameters: a 7-bit value field, a 3-bit day field and alarm addresses 3, 5 and 7. With a day field this narrow, all eight day codes can be swept. For each of the eight mask combinations, the bench sweeps all 60 BCD minute values, all 24 BCD hour values and every day code, and checks every evaluation against an arithmetic model of the rate decode and the re-arm rule. Directed cases cover 12-hour mode bits, acknowledgement by address, and a fire that coincides with an acknowledge.

// File: rtl/tam_pkg.sv
package tam_pkg;

  typedef enum logic [1:0] {
    RATE_FULL   = 2'd0,
    RATE_DAILY  = 2'd1,
    RATE_HOURLY = 2'd2,
    RATE_MINUTE = 2'd3
  } rate_e;

  // nested masks: a finer mask implies every coarser one
  function automatic rate_e rate_of(input logic min_m, input logic hour_m, input logic day_m);
    if (min_m)       return RATE_MINUTE;
    else if (hour_m) return RATE_HOURLY;
    else if (day_m)  return RATE_DAILY;
    else             return RATE_FULL;
  endfunction

endpackage

// File: rtl/tam_regs.sv
module tam_regs #(
  parameter int ADDR_W        = 4,
  parameter int VAL_W         = 7,
  parameter int DAY_W         = 3,
  parameter int ALM_MIN_ADDR  = 3,
  parameter int ALM_HOUR_ADDR = 5,
  parameter int ALM_DAY_ADDR  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VAL_W:0]    wdata_i,
  output logic [VAL_W:0]    rdata_o,
  output logic [VAL_W:0]    alm_min_o,
  output logic [VAL_W:0]    alm_hour_o,
  output logic [VAL_W:0]    alm_day_o,
  output logic              access_o,
  output logic              wr_hit_o
);

  localparam int DATA_W = VAL_W + 1;
  localparam logic [DATA_W-1:0] DAY_KEEP =
    {1'b1, {(VAL_W-DAY_W){1'b0}}, {DAY_W{1'b1}}};

  logic sel_min, sel_hour, sel_day, sel_any;

  assign sel_min  = (addr_i == ADDR_W'(ALM_MIN_ADDR));
  assign sel_hour = (addr_i == ADDR_W'(ALM_HOUR_ADDR));
  assign sel_day  = (addr_i == ADDR_W'(ALM_DAY_ADDR));
  assign sel_any  = sel_min | sel_hour | sel_day;

  assign access_o = (wr_i | rd_i) & sel_any;
  assign wr_hit_o = wr_i & sel_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_min_o  <= '0;
      alm_hour_o <= '0;
      alm_day_o  <= '0;
    end else if (wr_i) begin
      if (sel_min)  alm_min_o  <= wdata_i;
      if (sel_hour) alm_hour_o <= wdata_i;
      if (sel_day)  alm_day_o  <= wdata_i & DAY_KEEP;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_min)       rdata_o = alm_min_o;
    else if (sel_hour) rdata_o = alm_hour_o;
    else if (sel_day)  rdata_o = alm_day_o;
  end

  assert_day_pad_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_day) |=> (alm_day_o[VAL_W-1:DAY_W] == '0));

  assert_min_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_min) |=> (alm_min_o == $past(wdata_i)));

endmodule

// File: rtl/tam_match.sv
module tam_match
  import tam_pkg::*;
#(
  parameter int VAL_W = 7,
  parameter int DAY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VAL_W-1:0] cur_min_i,
  input  logic [VAL_W-1:0] cur_hour_i,
  input  logic [DAY_W-1:0] cur_day_i,
  input  logic [VAL_W:0]   alm_min_i,
  input  logic [VAL_W:0]   alm_hour_i,
  input  logic [VAL_W:0]   alm_day_i,
  input  logic             eval_stb_i,
  input  logic             sec_roll_i,
  input  logic             rearm_i,
  output logic             fire_o
);

  rate_e rate;
  logic  min_eq, hour_eq, day_eq, hit, match_q;

  assign rate    = rate_of(alm_min_i[VAL_W], alm_hour_i[VAL_W], alm_day_i[VAL_W]);
  assign min_eq  = (cur_min_i  == alm_min_i[VAL_W-1:0]);
  assign hour_eq = (cur_hour_i == alm_hour_i[VAL_W-1:0]);
  assign day_eq  = (cur_day_i  == alm_day_i[DAY_W-1:0]);

  always_comb begin
    unique case (rate)
      RATE_FULL:   hit = min_eq & hour_eq & day_eq;
      RATE_DAILY:  hit = min_eq & hour_eq;
      RATE_HOURLY: hit = min_eq;
      default:     hit = 1'b0;
    endcase
  end

  // remember last evaluation so a run of matches fires once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_q <= 1'b0;
    else if (rearm_i)    match_q <= 1'b0;
    else if (eval_stb_i) match_q <= hit;
  end

  assign fire_o = (eval_stb_i & hit & ~match_q) |
                  (sec_roll_i & (rate == RATE_MINUTE));

  assert_minute_on_roll_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && rate == RATE_MINUTE) |-> sec_roll_i);

  assert_no_repeat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && eval_stb_i && !rearm_i && rate != RATE_MINUTE)
      |=> !(fire_o && eval_stb_i && rate != RATE_MINUTE));

endmodule

// File: rtl/tam_flag.sv
module tam_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic access_i,
  output logic flag_o
);

  // firing wins over acknowledge so no alarm is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_o <= 1'b0;
    else if (fire_i)   flag_o <= 1'b1;
    else if (access_i) flag_o <= 1'b0;
  end

  assert_set_on_fire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_o);

  assert_clear_on_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !fire_i) |=> !flag_o);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !access_i) |=> flag_o);

endmodule

// File: rtl/tod_alarm_matcher.sv
module tod_alarm_matcher #(
  parameter int ADDR_W        = 4,
  parameter int VAL_W         = 7,
  parameter int DAY_W         = 3,
  parameter int ALM_MIN_ADDR  = 3,
  parameter int ALM_HOUR_ADDR = 5,
  parameter int ALM_DAY_ADDR  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VAL_W-1:0]  cur_min_i,
  input  logic [VAL_W-1:0]  cur_hour_i,
  input  logic [DAY_W-1:0]  cur_day_i,
  input  logic              eval_stb_i,
  input  logic              sec_roll_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [VAL_W:0]    bus_wdata_i,
  output logic [VAL_W:0]    bus_rdata_o,
  output logic              alarm_flag_o,
  output logic              alarm_irq_no
);

  logic [VAL_W:0] alm_min, alm_hour, alm_day;
  logic           access, wr_hit, fire;

  tam_regs #(
    .ADDR_W(ADDR_W), .VAL_W(VAL_W), .DAY_W(DAY_W),
    .ALM_MIN_ADDR(ALM_MIN_ADDR), .ALM_HOUR_ADDR(ALM_HOUR_ADDR),
    .ALM_DAY_ADDR(ALM_DAY_ADDR)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .alm_min_o(alm_min), .alm_hour_o(alm_hour), .alm_day_o(alm_day),
    .access_o(access), .wr_hit_o(wr_hit)
  );

  tam_match #(.VAL_W(VAL_W), .DAY_W(DAY_W)) i_match (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i), .cur_day_i(cur_day_i),
    .alm_min_i(alm_min), .alm_hour_i(alm_hour), .alm_day_i(alm_day),
    .eval_stb_i(eval_stb_i), .sec_roll_i(sec_roll_i), .rearm_i(wr_hit),
    .fire_o(fire)
  );

  tam_flag i_flag (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fire_i(fire), .access_i(access), .flag_o(alarm_flag_o)
  );

  assign alarm_irq_no = ~alarm_flag_o;

endmodule

// File: tb/test_tod_alarm_matcher.sv
module test_tod_alarm_matcher;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cur_min = '0, cur_hour = '0;
  logic [2:0] cur_day = '0;
  logic       eval_stb = 1'b0, sec_roll = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       flag, irq_n;

  int  n_checks = 0, n_errors = 0;
  bit  done = 1'b0;
  bit  prev_hit = 1'b0;
  logic [7:0] a_min = '0, a_hr = '0, a_day = '0;

  always #2 clk = ~clk;

  tod_alarm_matcher i_tod_alarm_matcher (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_min_i(cur_min), .cur_hour_i(cur_hour), .cur_day_i(cur_day),
    .eval_stb_i(eval_stb), .sec_roll_i(sec_roll),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .alarm_flag_o(flag), .alarm_irq_no(irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bcd(input int n);
    return 7'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
    if (a == 4'd3) a_min = d;
    if (a == 4'd5) a_hr  = d;
    if (a == 4'd7) a_day = d & 8'h87;
    if (a == 4'd3 || a == 4'd5 || a == 4'd7) prev_hit = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  // model of the rate decode and the re-arm rule
  function automatic bit model_eval(input logic [6:0] mn, input logic [6:0] hr, input logic [2:0] dy);
    bit mm, hm, dm, h, f;
    mm = a_min[7];
    hm = mm | a_hr[7];
    dm = hm | a_day[7];
    if (mm) h = 1'b0;
    else h = (mn == a_min[6:0]) && (hm || hr == a_hr[6:0]) && (dm || dy == a_day[2:0]);
    f = h && !prev_hit;
    prev_hit = h;
    return f;
  endfunction

  task automatic do_eval(input logic [6:0] mn, input logic [6:0] hr, input logic [2:0] dy,
                         input string tag);
    bit expf;
    logic [7:0] dmy;
    expf = model_eval(mn, hr, dy);
    cur_min = mn; cur_hour = hr; cur_day = dy; eval_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    eval_stb = 1'b0;
    chk(tag, flag, expf);
    rd_reg(4'd3, dmy);
  endtask

  task automatic do_roll(input string tag);
    logic [7:0] dmy;
    sec_roll = 1'b1;
    @(posedge clk); @(negedge clk);
    sec_roll = 1'b0;
    chk(tag, flag, a_min[7]);
    rd_reg(4'd3, dmy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    string tag;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 flag", flag, 0);
    chk("R11 irq", irq_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(4'd3, d); chk("R11 min reg", d, 0);
    rd_reg(4'd5, d); chk("R11 hour reg", d, 0);
    rd_reg(4'd7, d); chk("R11 day reg", d, 0);

    // R1 register map
    wr_reg(4'd3, 8'hA5); rd_reg(4'd3, d); chk("R1 min readback", d, 8'hA5);
    wr_reg(4'd5, 8'h5A); rd_reg(4'd5, d); chk("R1 hour readback", d, 8'h5A);
    wr_reg(4'd7, 8'hFF); rd_reg(4'd7, d); chk("R1 day pad bits", d, 8'h87);
    wr_reg(4'd2, 8'h33); rd_reg(4'd2, d); chk("R1 unmapped read", d, 0);

    // sweeps over every mask combination
    for (int code = 0; code < 8; code++) begin
      case (code)
        0: tag = "R2"; 4: tag = "R3"; 6: tag = "R4"; 7: tag = "R5";
        default: tag = "R6";
      endcase
      wr_reg(4'd3, {code[0], 7'h30});
      wr_reg(4'd5, {code[1], 7'h12});
      wr_reg(4'd7, {code[2], 7'h03});
      for (int m = 0; m < 60; m++) do_eval(bcd(m), 7'h12, 3'd3, {tag, " min sweep"});
      for (int h = 0; h < 24; h++) do_eval(7'h30, bcd(h), 3'd3, {tag, " hour sweep"});
      for (int dd = 0; dd < 8; dd++) do_eval(7'h30, 7'h12, 3'(dd), {tag, " day sweep"});
      do_roll("R5 seconds rollover");
    end

    // R2 12-hour mode bits take part in the compare
    wr_reg(4'd3, 8'h15); wr_reg(4'd5, 8'h52); wr_reg(4'd7, 8'h02);
    do_eval(7'h15, 7'h72, 3'd2, "R2 12h am/pm differs");
    do_eval(7'h15, 7'h12, 3'd2, "R2 24h vs 12h differs");
    do_eval(7'h15, 7'h52, 3'd2, "R2 12h exact");

    // R7 repeat suppression and re-arm by write
    do_eval(7'h15, 7'h52, 3'd2, "R7 repeat match");
    wr_reg(4'd3, 8'h15);
    do_eval(7'h15, 7'h52, 3'd2, "R7 rearmed by write");

    // R9 acknowledge by address, R8 sticky + irq
    wr_reg(4'd3, 8'h80);
    sec_roll = 1'b1; @(posedge clk); @(negedge clk); sec_roll = 1'b0;
    chk("R8 flag set", flag, 1);
    repeat (5) @(negedge clk);
    chk("R8 flag sticky", flag, 1);
    chk("R8 irq low", irq_n, 0);
    wr_reg(4'd2, 8'h00);
    chk("R9 write other addr", flag, 1);
    rd_reg(4'd9, d);
    chk("R9 read other addr", flag, 1);
    rd_reg(4'd5, d);
    chk("R9 read clears", flag, 0);
    chk("R8 irq high", irq_n, 1);
    sec_roll = 1'b1; @(posedge clk); @(negedge clk); sec_roll = 1'b0;
    chk("R8 flag set again", flag, 1);
    wr_reg(4'd7, 8'h00);
    chk("R9 write clears", flag, 0);

    // R10 fire and acknowledge in one cycle
    sec_roll = 1'b1; rd = 1'b1; addr = 4'd3;
    @(posedge clk); @(negedge clk);
    sec_roll = 1'b0; rd = 1'b0;
    chk("R10 fire beats ack", flag, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule